// File: doc/BRIEF.md
# Burst Address Generator

This block turns one burst descriptor into a stream of per-beat addresses with byte-lane enables. A requester offers a descriptor (start address, length code, beat-size code and burst kind) through a valid/ready handshake. Once accepted, the block emits one beat per handshake on its output side. Each beat carries the address of that beat, the byte lanes of a 32-bit data bus that the beat occupies, and a flag that marks the final beat.

Three address orderings are supported: a constant address, a plain incrementing address, and an incrementing address that folds back to the bottom of an aligned window. The byte-lane enables follow the low address bits, so narrow beats land on the correct lanes of the wider bus. A descriptor that cannot be served is consumed without producing beats, and an error pulse is raised. The block holds one burst at a time. It takes the next descriptor only after the final beat of the current burst has been handed over.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the block is idle: desc_ready is 1, beat_valid is 0 and desc_err is 0. A descriptor is taken on a rising edge where desc_valid and desc_ready are both 1.
- R2: An accepted valid descriptor with length code L yields exactly L+1 beats, and beat_last is 1 only on the final one. desc_ready stays 0 while beats remain, and it is 1 again in the cycle after the final beat handshake.
- R3: Kind code 2'b00 (constant): every beat carries the unchanged start address.
- R4: Kind code 2'b01 (incrementing): beat 0 carries the start address. Beat k>0 carries the start address rounded down to a multiple of 2^S, plus k*2^S, where S is the size code.
- R5: Kind code 2'b10 (wrapping): the start address is rounded down to a multiple of 2^S and used for beat 0. Later beats add 2^S each time. The address stays inside the window of (L+1)*2^S bytes that is aligned to its own size and contains the start, and it continues from the window base after the window top.
- R6: A wrapping descriptor whose beat count is not 2, 4, 8 or 16 is consumed without any beat. desc_err is 1 for exactly the one cycle after its handshake.
- R7: Kind code 2'b11 is reserved: the descriptor is consumed without any beat, and desc_err pulses as in R6.
- R8: A size code above 2 (beats wider than 4 bytes) is consumed without any beat, and desc_err pulses as in R6.
- R9: For a beat at address A with size code S, beat_strb bit i (byte lane i, little-endian) is 1 exactly when i >= A[1:0] and i < (A[1:0] rounded down to a multiple of 2^S) + 2^S.
- R10: While beat_valid is 1 and beat_ready is 0, beat_addr, beat_strb and beat_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block can take a descriptor |
| desc_addr | input | 32 | Start address |
| desc_len | input | 4 | Beat count minus one |
| desc_size | input | 3 | Bytes per beat as a power of two |
| desc_kind | input | 2 | 00 constant, 01 incrementing, 10 wrapping, 11 reserved |
| beat_valid | output | 1 | Beat on offer |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | 32 | Address of the current beat |
| beat_strb | output | 4 | Active byte lanes of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| desc_err | output | 1 | One-cycle pulse after an unserviceable descriptor |

## Verification
The hardest case to reach is a wrapping burst that starts part-way through its window with an unaligned address. In that case the round-down, the window base and the fold-back all take effect in the same burst, and this happens only for a few combinations of size, length and offset. The bench sweeps every kind, every size code and every length code against a set of start offsets. The set mixes aligned values, values one byte off, and values in the middle of a 64-byte window, so every legal window size sees a mid-window start. The consumer side is throttled by a pseudo-random ready pattern, which makes the hold-while-stalled rule happen on all kinds of beat.

// File: rtl/bag_pkg.sv
// Shared types for the burst address generator.
package bag_pkg;

    // Burst kind codes carried on the descriptor.
    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10,
        BK_RSVD  = 2'b11
    } burst_kind_e;

endpackage

// File: rtl/bag_desc_check.sv
// Decides whether a descriptor can be served.
// Assumes: size code gives 2^size bytes; MAX_SIZE is log2 of the bus width in bytes.
module bag_desc_check
    import bag_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int SIZE_W   = 3,
    parameter int MAX_SIZE = 2
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        kind,
    output logic              bad
);
    localparam int CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] count;
    logic             pow2_count;

    // Beat count is a power of two of at least two when it has one bit set and len is nonzero.
    always_comb begin
        count      = CNT_W'(len) + CNT_W'(1);
        pow2_count = (len != '0) && ((count & (count - CNT_W'(1))) == '0);
    end

    // Combine the three rejection causes.
    always_comb begin
        bad = 1'b0;
        if (kind == BK_RSVD)                      bad = 1'b1;
        if (size > SIZE_W'(MAX_SIZE))             bad = 1'b1;
        if ((kind == BK_WRAP) && !pow2_count)     bad = 1'b1;
    end

endmodule

// File: rtl/bag_addr_step.sv
// Computes the address of the next beat from the current one.
// Assumes: wrap_mask is window size minus one, window size a power of two.
module bag_addr_step
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] bumped;

    // Round the current address down to the beat size and advance one beat.
    always_comb begin
        step    = ADDR_W'(1) << size;
        aligned = cur_addr & ~(step - ADDR_W'(1));
        bumped  = aligned + step;
    end

    // Select the ordering rule for the burst kind.
    always_comb begin
        case (kind)
            BK_FIXED: next_addr = cur_addr;
            BK_WRAP:  next_addr = (cur_addr & ~wrap_mask) | (bumped & wrap_mask);
            default:  next_addr = bumped;
        endcase
    end

endmodule

// File: rtl/bag_lane_strobe.sv
// Derives byte-lane enables for one beat from the low address bits and the beat size.
// Assumes: size never exceeds log2(LANES); larger sizes are rejected upstream.
module bag_lane_strobe #(
    parameter int LANES  = 4,
    parameter int SIZE_W = 3
) (
    input  logic [$clog2(LANES)-1:0] lo_addr,
    input  logic [SIZE_W-1:0]        size,
    output logic [LANES-1:0]         strb
);
    localparam int LANE_W = $clog2(LANES);
    localparam int SPAN_W = LANE_W + 1;

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] first;
    logic [SPAN_W-1:0] limit;

    // Container of the beat: from the given byte up to the end of its size-aligned slot.
    always_comb begin
        span  = SPAN_W'(1) << size;
        first = SPAN_W'(lo_addr);
        limit = (first & ~(span - SPAN_W'(1))) + span;
    end

    // One comparator pair per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb[i] = (SPAN_W'(i) >= first) && (SPAN_W'(i) < limit);
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Burst address generator: accepts one descriptor, then emits one address and
// lane-enable set per beat handshake. Holds a single burst at a time.
// Assumes: bursts do not cross a 4 KB boundary; the start address is used as
// given only for the first beat of an incrementing burst.
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 4,
    parameter int LEN_W      = 4,
    parameter int SIZE_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  desc_valid,
    output logic                  desc_ready,
    input  logic [ADDR_W-1:0]     desc_addr,
    input  logic [LEN_W-1:0]      desc_len,
    input  logic [SIZE_W-1:0]     desc_size,
    input  logic [1:0]            desc_kind,
    output logic                  beat_valid,
    input  logic                  beat_ready,
    output logic [ADDR_W-1:0]     beat_addr,
    output logic [DATA_BYTES-1:0] beat_strb,
    output logic                  beat_last,
    output logic                  desc_err
);
    localparam int LANE_W   = $clog2(DATA_BYTES);
    localparam int MAX_SIZE = LANE_W;

    logic              busy_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [1:0]        kind_q;
    logic [SIZE_W-1:0] size_q;
    logic [ADDR_W-1:0] wmask_q;
    logic              err_q;

    logic              desc_bad;
    logic              desc_fire;
    logic              beat_fire;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] start_wmask;

    // Reject unserviceable descriptors.
    bag_desc_check #(
        .LEN_W    (LEN_W),
        .SIZE_W   (SIZE_W),
        .MAX_SIZE (MAX_SIZE)
    ) u_check (
        .len  (desc_len),
        .size (desc_size),
        .kind (desc_kind),
        .bad  (desc_bad)
    );

    // Next-beat address.
    bag_addr_step #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_step (
        .cur_addr  (addr_q),
        .size      (size_q),
        .kind      (kind_q),
        .wrap_mask (wmask_q),
        .next_addr (next_addr)
    );

    // Lane enables of the beat on offer.
    bag_lane_strobe #(
        .LANES  (DATA_BYTES),
        .SIZE_W (SIZE_W)
    ) u_strb (
        .lo_addr (addr_q[LANE_W-1:0]),
        .size    (size_q),
        .strb    (beat_strb)
    );

    // Handshake qualifiers.
    always_comb begin
        desc_ready = !busy_q;
        desc_fire  = desc_valid && desc_ready;
        beat_valid = busy_q;
        beat_fire  = beat_valid && beat_ready;
        beat_last  = busy_q && (left_q == '0);
        beat_addr  = addr_q;
        desc_err   = err_q;
    end

    // Starting address and wrap window mask of an incoming descriptor.
    always_comb begin
        start_wmask = ((ADDR_W'(desc_len) + ADDR_W'(1)) << desc_size) - ADDR_W'(1);
        if (desc_kind == BK_WRAP)
            start_addr = desc_addr & ~((ADDR_W'(1) << desc_size) - ADDR_W'(1));
        else
            start_addr = desc_addr;
    end

    // Burst state: load on descriptor, advance on each beat, release after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            addr_q  <= '0;
            left_q  <= '0;
            kind_q  <= BK_FIXED;
            size_q  <= '0;
            wmask_q <= '0;
        end else if (desc_fire && !desc_bad) begin
            busy_q  <= 1'b1;
            addr_q  <= start_addr;
            left_q  <= desc_len;
            kind_q  <= desc_kind;
            size_q  <= desc_size;
            wmask_q <= start_wmask;
        end else if (beat_fire) begin
            if (beat_last) begin
                busy_q <= 1'b0;
            end else begin
                addr_q <= next_addr;
                left_q <= left_q - LEN_W'(1);
            end
        end
    end

    // One-cycle error pulse after a rejected descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= desc_fire && desc_bad;
    end

endmodule

// File: rtl/bag_checker.sv
// Protocol and ordering properties of burst_addr_gen, observed at its ports.
// Keeps its own copy of the accepted descriptor's kind, size and wrap window.
module bag_checker
    import bag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 4,
    parameter int LEN_W      = 4,
    parameter int SIZE_W     = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  desc_valid,
    input logic                  desc_ready,
    input logic [ADDR_W-1:0]     desc_addr,
    input logic [LEN_W-1:0]      desc_len,
    input logic [SIZE_W-1:0]     desc_size,
    input logic [1:0]            desc_kind,
    input logic                  beat_valid,
    input logic                  beat_ready,
    input logic [ADDR_W-1:0]     beat_addr,
    input logic [DATA_BYTES-1:0] beat_strb,
    input logic                  beat_last,
    input logic                  desc_err
);
    logic              ck_fire;
    logic              ck_beat;
    logic [1:0]        ck_kind;
    logic [SIZE_W-1:0] ck_size;
    logic [ADDR_W-1:0] ck_mask;
    logic [ADDR_W-1:0] ck_base;
    logic [ADDR_W-1:0] ck_win;
    logic [ADDR_W-1:0] ck_unit;

    // Handshake events seen at the ports.
    always_comb begin
        ck_fire = desc_valid && desc_ready;
        ck_beat = beat_valid && beat_ready;
        ck_unit = ADDR_W'(1) << desc_size;
        ck_win  = (ADDR_W'(desc_len) + ADDR_W'(1)) * ck_unit;
    end

    // Capture the burst parameters at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_kind <= BK_FIXED;
            ck_size <= '0;
            ck_mask <= '0;
            ck_base <= '0;
        end else if (ck_fire) begin
            ck_kind <= desc_kind;
            ck_size <= desc_size;
            ck_mask <= ck_win - ADDR_W'(1);
            ck_base <= (desc_addr / ck_win) * ck_win;
        end
    end

    p_fire_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ck_fire |=> (beat_valid != desc_err));

    p_fixed_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_beat && !beat_last && ck_kind == BK_FIXED) |=> (beat_addr == $past(beat_addr)));

    p_incr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_beat && !beat_last && ck_kind == BK_INCR)
        |=> (beat_addr == ((($past(beat_addr) >> ck_size) << ck_size) + (ADDR_W'(1) << ck_size))));

    p_wrap_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && ck_kind == BK_WRAP) |-> ((beat_addr & ~ck_mask) == ck_base));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |-> (!beat_valid && desc_ready));

    p_strb_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_strb != '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready)
        |=> (beat_valid && $stable(beat_addr) && $stable(beat_strb) && $stable(beat_last)));

endmodule

bind burst_addr_gen bag_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_BYTES (DATA_BYTES),
    .LEN_W      (LEN_W),
    .SIZE_W     (SIZE_W)
) u_bag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_addr  (desc_addr),
    .desc_len   (desc_len),
    .desc_size  (desc_size),
    .desc_kind  (desc_kind),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_strb  (beat_strb),
    .beat_last  (beat_last),
    .desc_err   (desc_err)
);

// File: tb/sim_burst_addr_gen.sv
// Sweeps every kind, size code and length code over a set of start offsets,
// with a pseudo-random consumer, and compares against arithmetic expectations.
module sim_burst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [31:0] desc_addr = '0;
    logic [3:0]  desc_len = '0;
    logic [2:0]  desc_size = '0;
    logic [1:0]  desc_kind = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [3:0]  beat_strb;
    logic        beat_last;
    logic        desc_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    burst_addr_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_len(desc_len),
        .desc_size(desc_size), .desc_kind(desc_kind),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_strb(beat_strb),
        .beat_last(beat_last), .desc_err(desc_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Start offsets: aligned, off by one byte, and mid-window.
    function automatic logic [31:0] offset(input int i);
        case (i)
            0: return 32'h00;
            1: return 32'h01;
            2: return 32'h02;
            3: return 32'h03;
            4: return 32'h06;
            5: return 32'h17;
            6: return 32'h27;
            default: return 32'h3E;
        endcase
    endfunction

    // Expected address of beat k (R3, R4, R5).
    function automatic logic [31:0] exp_addr(input int kd, input logic [31:0] st,
                                             input int sz, input int n, input int k);
        int unsigned al, wb, base;
        al = (st / sz) * sz;
        if (kd == 0) return st;
        if (kd == 1) return (k == 0) ? st : al + k * sz;
        wb   = sz * n;
        base = (al / wb) * wb;
        return base + ((al - base + k * sz) % wb);
    endfunction

    // Expected lane enables (R9).
    function automatic logic [3:0] exp_strb(input logic [31:0] a, input int sz);
        int lo, first_end;
        logic [3:0] s;
        lo = int'(a % 4);
        first_end = (lo / sz) * sz + sz;
        for (int i = 0; i < 4; i++) s[i] = (i >= lo) && (i < first_end);
        return s;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic rdy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(desc_ready), 32'd1);
        chk("R1 no beat after reset", 32'(beat_valid), 32'd0);
        chk("R1 no error after reset", 32'(desc_err), 32'd0);

        for (int kd = 0; kd < 4; kd++)
        for (int sc = 0; sc < 4; sc++)
        for (int ln = 0; ln < 16; ln++)
        for (int oi = 0; oi < 8; oi++) begin
            int  n, sz;
            bit  bad;
            logic [31:0] st;
            n  = ln + 1;
            sz = 1 << sc;
            st = 32'h0000_2000 + offset(oi);
            bad = (kd == 3) || (sc > 2) ||
                  ((kd == 2) && !(n == 2 || n == 4 || n == 8 || n == 16));

            chk("R1 idle before descriptor", 32'(desc_ready), 32'd1);
            chk("R6 error pulse one cycle", 32'(desc_err), 32'd0);
            desc_valid = 1'b1;
            desc_addr  = st;
            desc_len   = 4'(ln);
            desc_size  = 3'(sc);
            desc_kind  = 2'(kd);
            @(negedge clk);
            desc_valid = 1'b0;

            if (bad) begin
                // R6 R7 R8: consumed, no beats, error pulse
                chk(kd == 3 ? "R7 reserved kind err" : (sc > 2 ? "R8 wide size err" : "R6 wrap count err"),
                    32'(desc_err), 32'd1);
                chk("R6 no beat on reject", 32'(beat_valid), 32'd0);
                @(negedge clk);
            end else begin
                for (int k = 0; k < n; k++) begin
                    logic [31:0] ea;
                    ea = exp_addr(kd, st, sz, n, k);
                    do begin
                        rdy  = lfsr[0] | lfsr[2];
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        beat_ready = rdy;
                        chk("R2 beat present", 32'(beat_valid), 32'd1);
                        chk("R2 busy blocks descriptor", 32'(desc_ready), 32'd0);
                        chk("R2 last flag", 32'(beat_last), 32'(k == n - 1));
                        chk(kd == 0 ? "R3 fixed addr" : (kd == 1 ? "R4 incr addr" : "R5 wrap addr"),
                            beat_addr, ea);
                        chk(rdy ? "R9 lane strobe" : "R10 strobe held", 32'(beat_strb),
                            32'(exp_strb(ea, sz)));
                        @(negedge clk);
                    end while (!rdy);
                end
                beat_ready = 1'b0;
                chk("R2 beats end", 32'(beat_valid), 32'd0);
                chk("R2 ready after last", 32'(desc_ready), 32'd1);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule